// File: doc/BRIEF.md
# Serial-Presence Memory Write-Protect Controller

This block holds a 256-byte configuration memory, organised as 16 pages of 16 bytes, and serves it through a decoded command interface. The bit-level serial protocol has already been taken apart before this block sees anything. It receives one command strobe with a command code and an address, a stream of data-byte strobes for writes, a next-byte strobe for reads, and a stop strobe that closes the current transfer. Each command is answered one cycle later by an acknowledge pulse, or by the lack of one.

Software protection guards only the lower half of the memory, addresses 00h to 7Fh. It comes in two kinds. A permanent lock can never be removed. A reversible lock is lifted only by its dedicated clear command. Three query commands report the lock state through the acknowledge alone. After a write or a lock change, a program-cycle timer stands in for the non-volatile programming time, and during that time every command is refused. The memory contents and the lock flags start from their erased state, all bytes FFh and no lock, at reset.

Top module: `spd_wp_ctrl`

## Requirements
- R1: After reset, `busy`, `cmd_ack` and `rd_valid` are 0, every byte reads FFh, and no lock is set.
- R2: Command codes on `cmd_type` are: 0 memory write, 1 memory read, 2 set permanent lock, 3 set reversible lock, 4 clear reversible lock, 5 query permanent, 6 query reversible, 7 query clear-ability. A command accepted on a clock edge gives `cmd_ack`=1 in the following cycle. A byte written and then read back returns the written value.
- R3: Address bits [7:4] pick the page and bits [3:0] the byte. During a write, each data byte advances only the in-page offset, which wraps from 15 to 0 inside the same page.
- R4: A write may carry 1, 2, 4, 8 or 16 bytes. Exactly the bytes sent are changed, and the neighbouring bytes keep their values.
- R5: A write that starts at 80h–FFh is acknowledged and takes effect whatever the lock state.
- R6: Once the permanent lock is set, it stays set until reset. A write starting at 00h–7Fh is then not acknowledged and leaves the memory unchanged. The set-permanent, set-reversible and clear-reversible commands are then not acknowledged.
- R7: While the reversible lock is set, a write starting at 00h–7Fh is not acknowledged and leaves the memory unchanged. Only an acknowledged clear-reversible command removes the lock.
- R8: A read presents the byte at the command address on `rd_data` in the cycle after the command. Each `rd_next` advances by one address, and FFh is followed by 00h.
- R9: A stop that closes a write of at least one byte, or any acknowledged lock-change command, holds `busy` high for exactly PROG_CYCLES cycles. While `busy` is high, no command is acknowledged and none has any effect. A write closed with no data bytes does not start the timer.
- R10: Query permanent and query clear-ability are acknowledged exactly when the permanent lock is clear. Query reversible is acknowledged exactly when the reversible lock is clear. Queries never start the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe (start of transfer) |
| cmd_type | input | 3 | Command code, see R2 |
| cmd_addr | input | 8 | Byte address for memory commands |
| wr_valid | input | 1 | Data-byte strobe during a write |
| wr_data | input | 8 | Data byte |
| rd_next | input | 1 | Host accepted the current read byte; advance |
| stop | input | 1 | Ends the current transfer |
| cmd_ack | output | 1 | One-cycle acknowledge of the previous cycle's command |
| rd_data | output | 8 | Current read byte |
| rd_valid | output | 1 | A read transfer is open |
| busy | output | 1 | Program cycle in progress |

## Verification
Writes are tried at a single byte, as a 4-byte run that crosses the page end, as an 8-byte partial page and as a 17-byte run. The first shows basic storage. The second separates in-page wrapping from a linear address step. The third separates a partial page from a full one. The last shows that overrun bytes overwrite the start of the page. Lower- and upper-half writes are repeated under no lock, under the reversible lock, after its clear, and under the permanent lock, so a lock that leaks into the upper half, or one that releases early, shows as a wrong acknowledge or a changed byte. The sequential read is started at FFh and checked to fetch 00h next. Commands issued during the program cycle, and empty writes, show whether the timer is gated correctly.

// File: rtl/spd_wp_pkg.sv
// Shared command and state encodings for the write-protect controller.
// Assumes a 3-bit command code decoded upstream of this block.
package spd_wp_pkg;

    typedef enum logic [2:0] {
        CMD_MEM_WR   = 3'd0,
        CMD_MEM_RD   = 3'd1,
        CMD_SET_PERM = 3'd2,
        CMD_SET_REV  = 3'd3,
        CMD_CLR_REV  = 3'd4,
        CMD_Q_PERM   = 3'd5,
        CMD_Q_REV    = 3'd6,
        CMD_Q_CLR    = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } st_e;

endpackage

// File: rtl/spd_wp_prot.sv
// Lock flags for the lower half of the array and the address-lock decision.
// Assumes the caller raises set_rev/clr_rev only when the permanent lock is clear.
module spd_wp_prot #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_perm,
    input  logic              set_rev,
    input  logic              clr_rev,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              perm,
    output logic              rev,
    output logic              addr_locked
);

    // Lower half is guarded by either lock; upper half never is.
    assign addr_locked = !chk_addr[ADDR_W-1] && (perm || rev);

    // Permanent lock: set once, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) perm <= 1'b0;
        else if (set_perm) perm <= 1'b1;
    end

    // Reversible lock: set and cleared only by its own commands.
    always_ff @(posedge clk) begin
        if (!rst_n) rev <= 1'b0;
        else if (set_rev) rev <= 1'b1;
        else if (clr_rev) rev <= 1'b0;
    end

    assert_perm_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        perm |=> perm);
    assert_rev_clear_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rev) |-> $past(clr_rev));
    assert_rev_set_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rev) |-> $past(set_rev));

endmodule

// File: rtl/spd_wp_array.sv
// Byte array with one synchronous write port and one combinational read port.
// Contents return to the erased value (all ones) on reset, standing in for a fresh part.
module spd_wp_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: erase on reset, otherwise one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: the selected byte, no latency.
    assign rdata = mem[raddr];

endmodule

// File: rtl/spd_wp_timer.sv
// Program-cycle timer: busy for exactly CYCLES cycles after a start pulse.
// Assumes CYCLES >= 1; a start while running reloads the count.
module spd_wp_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Down-counter loaded on start, stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (start) cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_end_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == CW'(1)));

endmodule

// File: rtl/spd_wp_ctrl.sv
// Top: decodes commands, runs write/read transfers with in-page address wrap,
// applies lower-half write locking and refuses commands during the program cycle.
// Assumes one strobe per cycle from an upstream bus decoder; stop closes a transfer.
module spd_wp_ctrl
    import spd_wp_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_next,
    input  logic              stop,
    output logic              cmd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    st_e               state_q;
    logic [ADDR_W-1:0] wptr_q;
    logic [ADDR_W-1:0] rptr_q;
    logic              wrote_q;
    logic              perm, rev, addr_locked;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic              mem_we;
    logic              accept;
    logic              ack_d, go_wr, go_rd;
    logic              set_perm_p, set_rev_p, clr_rev_p;
    logic              prog_start;
    cmd_e              cmd;

    assign cmd    = cmd_e'(cmd_type);
    assign accept = cmd_valid && (state_q == ST_IDLE) && !busy;

    // Command decode: acknowledge decision and the single action it triggers.
    always_comb begin
        ack_d      = 1'b0;
        go_wr      = 1'b0;
        go_rd      = 1'b0;
        set_perm_p = 1'b0;
        set_rev_p  = 1'b0;
        clr_rev_p  = 1'b0;
        if (accept) begin
            case (cmd)
                CMD_MEM_WR: begin
                    ack_d = !addr_locked;
                    go_wr = !addr_locked;
                end
                CMD_MEM_RD: begin
                    ack_d = 1'b1;
                    go_rd = 1'b1;
                end
                CMD_SET_PERM: begin
                    ack_d      = !perm;
                    set_perm_p = !perm;
                end
                CMD_SET_REV: begin
                    ack_d     = !perm;
                    set_rev_p = !perm;
                end
                CMD_CLR_REV: begin
                    ack_d     = !perm;
                    clr_rev_p = !perm;
                end
                CMD_Q_PERM: ack_d = !perm;
                CMD_Q_REV:  ack_d = !rev;
                CMD_Q_CLR:  ack_d = !perm;
                default:    ack_d = 1'b0;
            endcase
        end
    end

    assign mem_we     = (state_q == ST_WRITE) && wr_valid;
    assign mem_raddr  = (state_q == ST_READ) ? rptr_q : cmd_addr;
    assign prog_start = set_perm_p || set_rev_p || clr_rev_p ||
                        ((state_q == ST_WRITE) && stop && (wrote_q || wr_valid));

    spd_wp_prot #(.ADDR_W(ADDR_W)) u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_perm   (set_perm_p),
        .set_rev    (set_rev_p),
        .clr_rev    (clr_rev_p),
        .chk_addr   (cmd_addr),
        .perm       (perm),
        .rev        (rev),
        .addr_locked(addr_locked)
    );

    spd_wp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(wptr_q),
        .wdata(wr_data),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    spd_wp_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(prog_start),
        .busy (busy)
    );

    // Transfer sequencer: write pointer with in-page wrap, read pointer, outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wptr_q   <= '0;
            rptr_q   <= '0;
            wrote_q  <= 1'b0;
            cmd_ack  <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            cmd_ack <= ack_d;
            case (state_q)
                ST_IDLE: begin
                    if (go_wr) begin
                        state_q <= ST_WRITE;
                        wptr_q  <= cmd_addr;
                        wrote_q <= 1'b0;
                    end else if (go_rd) begin
                        state_q  <= ST_READ;
                        rd_data  <= mem_rdata;
                        rd_valid <= 1'b1;
                        rptr_q   <= cmd_addr + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (wr_valid) begin
                        wptr_q  <= {wptr_q[ADDR_W-1:OFF_W], wptr_q[OFF_W-1:0] + 1'b1};
                        wrote_q <= 1'b1;
                    end
                    if (stop) state_q <= ST_IDLE;
                end
                ST_READ: begin
                    if (stop) begin
                        state_q  <= ST_IDLE;
                        rd_valid <= 1'b0;
                    end else if (rd_next) begin
                        rd_data <= mem_rdata;
                        rptr_q  <= rptr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !cmd_ack);
    assert_no_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);
    assert_lower_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wptr_q[ADDR_W-1]) |-> !(perm || rev));
    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WRITE) && $past(state_q == ST_WRITE))
        |-> (wptr_q[ADDR_W-1:OFF_W] == $past(wptr_q[ADDR_W-1:OFF_W])));
    assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_READ) && $past(state_q == ST_READ) && $past(rd_next) && $past(!stop))
        |-> (rptr_q == ADDR_W'($past(rptr_q) + 1'b1)));

endmodule

// File: tb/spd_wp_ctrl_tb.sv
// Bench: a vector table walked by one loop, then directed reset and corner tests.
module spd_wp_ctrl_tb;

    localparam int PROG = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_type = '0;
    logic [7:0] cmd_addr = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_next = 1'b0;
    logic       stop = 1'b0;
    logic       cmd_ack;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spd_wp_ctrl #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_next(rd_next), .stop(stop), .cmd_ack(cmd_ack), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy)
    );

    // Vector fields: op[27:24] typ[23:21] adr[20:13] dat[12:5] exp[4] req[3:0]
    // op: 0 command+ack check, 1 data byte, 2 stop, 3 wait idle, 4 read check+advance
    localparam int NV = 96;
    localparam logic [27:0] VEC [NV] = '{
        {4'd0,3'd5,8'h00,8'h00,1'b1,4'd10},  // 1  R10 query perm, unlocked
        {4'd0,3'd6,8'h00,8'h00,1'b1,4'd10},  // 2  R10 query rev, unlocked
        {4'd0,3'd0,8'h00,8'h00,1'b1,4'd2},   // 3  R2 write 00
        {4'd1,3'd0,8'h00,8'h9E,1'b0,4'd2},   // 4
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd2},   // 5
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd2},   // 6
        {4'd0,3'd0,8'h05,8'h00,1'b1,4'd2},   // 7  R2 write 05
        {4'd1,3'd0,8'h00,8'hAA,1'b0,4'd2},   // 8
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd2},   // 9
        {4'd0,3'd1,8'h00,8'h00,1'b0,4'd9},   // 10 R9 read refused while busy
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd9},   // 11
        {4'd0,3'd1,8'h04,8'h00,1'b1,4'd2},   // 12 R2 read 04..06
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd2},   // 13
        {4'd4,3'd0,8'h00,8'hAA,1'b0,4'd2},   // 14
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd2},   // 15
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd2},   // 16
        {4'd0,3'd0,8'h2E,8'h00,1'b1,4'd3},   // 17 R3 4 bytes across page end
        {4'd1,3'd0,8'h00,8'h11,1'b0,4'd3},   // 18
        {4'd1,3'd0,8'h00,8'h22,1'b0,4'd3},   // 19
        {4'd1,3'd0,8'h00,8'h33,1'b0,4'd3},   // 20
        {4'd1,3'd0,8'h00,8'h44,1'b0,4'd3},   // 21
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd3},   // 22
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd3},   // 23
        {4'd0,3'd1,8'h2E,8'h00,1'b1,4'd3},   // 24
        {4'd4,3'd0,8'h00,8'h11,1'b0,4'd3},   // 25
        {4'd4,3'd0,8'h00,8'h22,1'b0,4'd3},   // 26
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd3},   // 27 30h untouched
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd3},   // 28
        {4'd0,3'd1,8'h20,8'h00,1'b1,4'd3},   // 29
        {4'd4,3'd0,8'h00,8'h33,1'b0,4'd3},   // 30 wrapped into 20h
        {4'd4,3'd0,8'h00,8'h44,1'b0,4'd3},   // 31
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd3},   // 32
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd3},   // 33
        {4'd0,3'd0,8'h40,8'h00,1'b1,4'd4},   // 34 R4 8-byte partial page
        {4'd1,3'd0,8'h00,8'h01,1'b0,4'd4},   // 35
        {4'd1,3'd0,8'h00,8'h02,1'b0,4'd4},   // 36
        {4'd1,3'd0,8'h00,8'h03,1'b0,4'd4},   // 37
        {4'd1,3'd0,8'h00,8'h04,1'b0,4'd4},   // 38
        {4'd1,3'd0,8'h00,8'h05,1'b0,4'd4},   // 39
        {4'd1,3'd0,8'h00,8'h06,1'b0,4'd4},   // 40
        {4'd1,3'd0,8'h00,8'h07,1'b0,4'd4},   // 41
        {4'd1,3'd0,8'h00,8'h08,1'b0,4'd4},   // 42
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd4},   // 43
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd4},   // 44
        {4'd0,3'd1,8'h46,8'h00,1'b1,4'd4},   // 45
        {4'd4,3'd0,8'h00,8'h07,1'b0,4'd4},   // 46
        {4'd4,3'd0,8'h00,8'h08,1'b0,4'd4},   // 47
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd4},   // 48 48h untouched
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd4},   // 49
        {4'd0,3'd3,8'h00,8'h00,1'b1,4'd7},   // 50 R7 set reversible
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd7},   // 51
        {4'd0,3'd6,8'h00,8'h00,1'b0,4'd10},  // 52 R10 query rev, locked
        {4'd0,3'd5,8'h00,8'h00,1'b1,4'd10},  // 53 R10 query perm, clear
        {4'd0,3'd0,8'h05,8'h00,1'b0,4'd7},   // 54 R7 lower write refused
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd7},   // 55
        {4'd0,3'd0,8'h85,8'h00,1'b1,4'd5},   // 56 R5 upper write allowed
        {4'd1,3'd0,8'h00,8'h5A,1'b0,4'd5},   // 57
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd5},   // 58
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd5},   // 59
        {4'd0,3'd1,8'h04,8'h00,1'b1,4'd7},   // 60 R7 lower unchanged
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd7},   // 61
        {4'd4,3'd0,8'h00,8'hAA,1'b0,4'd7},   // 62
        {4'd4,3'd0,8'h00,8'hFF,1'b0,4'd7},   // 63
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd7},   // 64
        {4'd0,3'd1,8'h85,8'h00,1'b1,4'd5},   // 65
        {4'd4,3'd0,8'h00,8'h5A,1'b0,4'd5},   // 66
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd5},   // 67
        {4'd0,3'd4,8'h00,8'h00,1'b1,4'd7},   // 68 R7 clear reversible
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd7},   // 69
        {4'd0,3'd6,8'h00,8'h00,1'b1,4'd10},  // 70 R10 query rev, clear again
        {4'd0,3'd0,8'h05,8'h00,1'b1,4'd7},   // 71 R7 lower write allowed
        {4'd1,3'd0,8'h00,8'h55,1'b0,4'd7},   // 72
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd7},   // 73
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd7},   // 74
        {4'd0,3'd2,8'h00,8'h00,1'b1,4'd6},   // 75 R6 set permanent
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd6},   // 76
        {4'd0,3'd5,8'h00,8'h00,1'b0,4'd10},  // 77 R10 query perm, locked
        {4'd0,3'd7,8'h00,8'h00,1'b0,4'd10},  // 78 R10 query clear-ability
        {4'd0,3'd4,8'h00,8'h00,1'b0,4'd6},   // 79 R6 clear rev refused
        {4'd0,3'd3,8'h00,8'h00,1'b0,4'd6},   // 80 R6 set rev refused
        {4'd0,3'd2,8'h00,8'h00,1'b0,4'd6},   // 81 R6 set perm refused
        {4'd0,3'd0,8'h05,8'h00,1'b0,4'd6},   // 82 R6 lower write refused
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd6},   // 83
        {4'd0,3'd0,8'h7F,8'h00,1'b0,4'd6},   // 84 R6 top of lower half
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd6},   // 85
        {4'd0,3'd1,8'h05,8'h00,1'b1,4'd6},   // 86
        {4'd4,3'd0,8'h00,8'h55,1'b0,4'd6},   // 87 unchanged
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd6},   // 88
        {4'd0,3'd0,8'hFF,8'h00,1'b1,4'd5},   // 89 R5 upper write under perm
        {4'd1,3'd0,8'h00,8'hC3,1'b0,4'd5},   // 90
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd5},   // 91
        {4'd3,3'd0,8'h00,8'h00,1'b0,4'd5},   // 92
        {4'd0,3'd1,8'hFF,8'h00,1'b1,4'd8},   // 93 R8 wrap FFh -> 00h
        {4'd4,3'd0,8'h00,8'hC3,1'b0,4'd8},   // 94
        {4'd4,3'd0,8'h00,8'h9E,1'b0,4'd8},   // 95
        {4'd2,3'd0,8'h00,8'h00,1'b0,4'd8}    // 96
    };

    task automatic chk(input bit ok, input int req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic t_cmd(input logic [2:0] typ, input logic [7:0] adr, output logic ack);
        cmd_valid = 1'b1; cmd_type = typ; cmd_addr = adr;
        @(negedge clk);
        cmd_valid = 1'b0;
        ack = cmd_ack;
    endtask

    task automatic t_wr(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic t_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic t_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic t_rd(output logic [7:0] d);
        d = rd_data;
        rd_next = 1'b1;
        @(negedge clk);
        rd_next = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        int         n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !cmd_ack && !rd_valid, 1, {busy, cmd_ack, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            case (v[27:24])
                4'd0: begin
                    t_cmd(v[23:21], v[20:13], a);
                    chk(a == v[4], int'(v[3:0]), a, v[4]);
                end
                4'd1: t_wr(v[12:5]);
                4'd2: t_stop();
                4'd3: t_idle();
                default: begin
                    t_rd(d);
                    chk(d == v[12:5], int'(v[3:0]), d, v[12:5]);
                end
            endcase
        end

        // R1: reset in the middle of a read clears outputs and locks, erases memory
        t_cmd(3'd1, 8'h05, a);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !cmd_ack && !rd_valid, 1, {busy, cmd_ack, rd_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_cmd(3'd5, 8'h00, a);
        chk(a == 1'b1, 1, a, 1);
        t_cmd(3'd1, 8'h05, a);
        chk(rd_valid && rd_data == 8'hFF, 1, rd_data, 8'hFF);
        t_stop();

        // R9: program cycle length after a one-byte write
        t_cmd(3'd0, 8'h90, a);
        t_wr(8'h12);
        t_stop();
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(n == PROG, 9, n, PROG);

        // R9: empty write does not start the timer
        t_cmd(3'd0, 8'h91, a);
        t_stop();
        chk(!busy, 9, busy, 0);

        // R3 / R4: 17 bytes into one page, the last overwrites the first
        t_cmd(3'd0, 8'hA3, a);
        for (int k = 0; k <= 16; k++) t_wr(8'h60 + 8'(k));
        t_stop();
        t_idle();
        t_cmd(3'd1, 8'hA3, a);
        t_rd(d);
        chk(d == 8'h70, 3, d, 8'h70);
        t_rd(d);
        chk(d == 8'h61, 4, d, 8'h61);
        t_stop();
        t_cmd(3'd1, 8'hA2, a);
        t_rd(d);
        chk(d == 8'h6F, 3, d, 8'h6F);
        t_stop();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule